// File: doc/BRIEF.md
# Character Display Memory Access Controller

This block sits between a byte-wide host register bus and a single-ported character memory of 512 locations. Each location pairs an 8-bit character code with a 3-bit attribute. The host sets a mode, a location and a byte plane through a few registers. It then moves data through a data-in register and a pair of data-out registers. A second, display-side port fetches locations for the video pipeline.

The host can work on one byte plane at a time (byte mode) or on a whole location (word mode). In word mode a written code carries the attribute held in the mode register. For streaming text there is an auto-increment mode: each code written lands at the current location, then the location advances. The reserved code FFh ends the stream. The host always wins the memory port. A display fetch that lands in the same cycle as a host memory access is dropped, and the drop is flagged on the display side.

Top module: `char_mem_ctrl`

## Requirements
- R1: After reset the mode, high-address and low-address registers read 0. rd_valid, disp_valid and disp_collision are low.
- R2: reg_sel selects a register: 0 mode, 1 high address, 2 low address, 3 data-in (write only), 4 data-out first byte, 5 data-out second byte. In the high-address register, bit 0 is address bit 8 and bit 1 is the plane select. A read of select 0, 1 or 2 returns the stored value, with rd_valid high, in the cycle after reg_rd.
- R3: With mode bit 0 = 0 and mode bit 6 = 0 (word mode), a data-in write stores the byte as the character code at the current location. The attribute stored with it is taken from mode bits [5:3]. The address does not change.
- R4: With mode bit 6 = 1 and mode bit 0 = 0 (byte mode), a data-in write touches only one plane. Plane select 0 writes the code. Plane select 1 writes the attribute from data-in bits [5:3]. The other plane keeps its value.
- R5: In word mode, a read of select 4 returns the location's character code in the next cycle. A later read of select 5 returns that location's attribute in bits [2:0], with bits [7:3] zero.
- R6: In byte mode, a read of select 4 returns the selected plane: the code byte, or the attribute in bits [2:0] with the rest zero.
- R7: With mode bit 0 = 1, each data-in write of a value other than FFh stores the code, with the attribute from mode bits [5:3], whatever the value of mode bit 6. The address then advances by one and wraps from 511 to 0.
- R8: A data-in write of FFh while mode bit 0 = 1 stores nothing and leaves the address unchanged. It clears mode bit 0 and keeps the other mode bits.
- R9: A display fetch (disp_req with disp_addr) made in a cycle without a host memory access returns disp_valid high the next cycle. It returns the location's code and attribute, with disp_collision low.
- R10: A display fetch in the same cycle as a host memory access (a storing data-in write or a select-4 read) is dropped. The next cycle shows disp_valid low and disp_collision high, and the host access completes. Register writes and FFh stream terminations are not memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| disp_req | input | 1 | Display fetch request |
| disp_addr | input | 9 | Display fetch location |
| disp_valid | output | 1 | Display fetch data valid |
| disp_code | output | 8 | Fetched character code |
| disp_attr | output | 3 | Fetched attribute |
| disp_collision | output | 1 | Display fetch dropped for a host access |

## Verification
Assertions check on every cycle that a colliding display fetch turns into a flagged drop. They also check that an uncontested fetch always yields valid data, and that valid display data only follows a request. In the stream mode they check that each stored code advances the location by exactly one and that a terminator freezes it. Only the bench's scenarios can show what actually lands in memory. That covers plane isolation in byte mode, the attribute drawn from the mode register, the changed bit positions of read-back attributes, wrap-around from 511 to 0, and the fact that a terminator stores nothing.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    localparam int BYTE_W      = 8;
    localparam int ATTR_W      = 3;
    localparam int ATTR_WR_LSB = 3;
    localparam int MODE_AUTO   = 0;
    localparam int MODE_BYTE   = 6;
    localparam logic [BYTE_W-1:0] STREAM_END = 8'hFF;

    typedef enum logic [2:0] {
        SEL_MODE      = 3'd0,
        SEL_ADDR_HI   = 3'd1,
        SEL_ADDR_LO   = 3'd2,
        SEL_DIN       = 3'd3,
        SEL_DOUT      = 3'd4,
        SEL_DOUT_ATTR = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/cmc_ram.sv
module cmc_ram
    import cmc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              re,
    input  logic              we_code,
    input  logic              we_attr,
    input  logic [BYTE_W-1:0] wcode,
    input  logic [ATTR_W-1:0] wattr,
    output logic [BYTE_W-1:0] rcode,
    output logic [ATTR_W-1:0] rattr
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] code_mem [DEPTH];
    logic [ATTR_W-1:0] attr_mem [DEPTH];
    logic [BYTE_W-1:0] rcode_q;
    logic [ATTR_W-1:0] rattr_q;

    always_ff @(posedge clk) begin
        if (we_code) code_mem[addr] <= wcode;
        if (we_attr) attr_mem[addr] <= wattr;
        if (re) begin
            rcode_q <= code_mem[addr];
            rattr_q <= attr_mem[addr];
        end
    end

    assign rcode = rcode_q;
    assign rattr = rattr_q;
endmodule

// File: rtl/cmc_arbiter.sv
module cmc_arbiter
    import cmc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_re,
    input  logic              h_we_code,
    input  logic              h_we_attr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              disp_req,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we_code,
    output logic              ram_we_attr,
    output logic              disp_valid,
    output logic              disp_collision
);
    typedef struct packed {
        logic valid;
        logic coll;
    } arb_state_t;

    arb_state_t s_q, s_d;
    logic       host_acc;

    always_comb begin
        host_acc    = h_re | h_we_code | h_we_attr;
        ram_addr    = host_acc ? h_addr : disp_addr;
        ram_re      = h_re | (disp_req & ~host_acc);
        ram_we_code = h_we_code;
        ram_we_attr = h_we_attr;
        s_d.valid   = disp_req & ~host_acc;
        s_d.coll    = disp_req & host_acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign disp_valid     = s_q.valid;
    assign disp_collision = s_q.coll;

    // R10: a host memory access always wins and the fetch is reported as dropped
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && (h_re || h_we_code || h_we_attr)) |=> (disp_collision && !disp_valid));

    // R9: an uncontested fetch returns data the next cycle
    p_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && !h_re && !h_we_code && !h_we_attr) |=> (disp_valid && !disp_collision));

    // R9: valid display data only follows a request
    p_valid_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(disp_req));
endmodule

// File: rtl/cmc_host.sv
module cmc_host
    import cmc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] ram_code,
    input  logic [ATTR_W-1:0] ram_attr,
    output logic              h_re,
    output logic              h_we_code,
    output logic              h_we_attr,
    output logic [ADDR_W-1:0] h_addr,
    output logic [BYTE_W-1:0] h_code,
    output logic [ATTR_W-1:0] h_attr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic              plane;
        logic [HI_W-1:0]   msb;
        logic [BYTE_W-1:0] lo;
        logic [ATTR_W-1:0] attr_hold;
        logic [BYTE_W-1:0] rd_byte;
        logic              rd_valid;
        logic              rd_mem;
        logic              rd_attr;
        logic              cap_attr;
    } host_state_t;

    host_state_t       s_q, s_d;
    logic [ADDR_W-1:0] cur_addr;
    logic              auto_on;
    logic              byte_mode;
    reg_sel_e          sel;

    always_comb begin
        s_d       = s_q;
        sel       = reg_sel_e'(reg_sel);
        cur_addr  = {s_q.msb, s_q.lo};
        auto_on   = s_q.mode[MODE_AUTO];
        byte_mode = s_q.mode[MODE_BYTE];
        h_re      = 1'b0;
        h_we_code = 1'b0;
        h_we_attr = 1'b0;
        h_addr    = cur_addr;
        h_code    = reg_wdata;
        h_attr    = s_q.mode[ATTR_WR_LSB +: ATTR_W];

        s_d.rd_valid = 1'b0;
        s_d.cap_attr = 1'b0;
        if (s_q.cap_attr) s_d.attr_hold = ram_attr;

        if (reg_wr) begin
            case (sel)
                SEL_MODE:    s_d.mode = reg_wdata;
                SEL_ADDR_HI: begin
                    s_d.msb   = reg_wdata[HI_W-1:0];
                    s_d.plane = reg_wdata[HI_W];
                end
                SEL_ADDR_LO: s_d.lo = reg_wdata;
                SEL_DIN: begin
                    if (auto_on) begin
                        if (reg_wdata == STREAM_END) begin
                            s_d.mode[MODE_AUTO] = 1'b0;
                        end else begin
                            h_we_code = 1'b1;
                            h_we_attr = 1'b1;
                            {s_d.msb, s_d.lo} = cur_addr + ADDR_W'(1);
                        end
                    end else if (byte_mode) begin
                        if (s_q.plane) begin
                            h_we_attr = 1'b1;
                            h_attr    = reg_wdata[ATTR_WR_LSB +: ATTR_W];
                        end else begin
                            h_we_code = 1'b1;
                        end
                    end else begin
                        h_we_code = 1'b1;
                        h_we_attr = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (reg_rd) begin
            s_d.rd_valid = 1'b1;
            s_d.rd_mem   = 1'b0;
            s_d.rd_attr  = 1'b0;
            case (sel)
                SEL_MODE:    s_d.rd_byte = s_q.mode;
                SEL_ADDR_HI: s_d.rd_byte = BYTE_W'({s_q.plane, s_q.msb});
                SEL_ADDR_LO: s_d.rd_byte = s_q.lo;
                SEL_DOUT: begin
                    h_re         = 1'b1;
                    s_d.rd_mem   = 1'b1;
                    s_d.rd_attr  = byte_mode & s_q.plane;
                    s_d.cap_attr = ~byte_mode;
                end
                SEL_DOUT_ATTR: s_d.rd_byte = BYTE_W'(s_d.attr_hold);
                default:       s_d.rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_mem ? (s_q.rd_attr ? BYTE_W'(ram_attr) : ram_code)
                                 : s_q.rd_byte;

    // R7: every stored stream code advances the location by exactly one
    p_autoinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_DIN && s_q.mode[MODE_AUTO] && reg_wdata != STREAM_END)
        |=> ({s_q.msb, s_q.lo} == ADDR_W'($past({s_q.msb, s_q.lo}) + ADDR_W'(1))));

    // R8: the terminator leaves stream mode and freezes the location
    p_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_DIN && s_q.mode[MODE_AUTO] && reg_wdata == STREAM_END)
        |=> (!s_q.mode[MODE_AUTO] && $stable({s_q.msb, s_q.lo})));

    // R2: every read strobe is answered the next cycle
    p_rdvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr) |=> rd_valid);
endmodule

// File: rtl/char_mem_ctrl.sv
module char_mem_ctrl
    import cmc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              disp_req,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic              disp_valid,
    output logic [7:0]        disp_code,
    output logic [2:0]        disp_attr,
    output logic              disp_collision
);
    logic              h_re, h_we_code, h_we_attr;
    logic [ADDR_W-1:0] h_addr;
    logic [BYTE_W-1:0] h_code;
    logic [ATTR_W-1:0] h_attr;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_re, ram_we_code, ram_we_attr;
    logic [BYTE_W-1:0] ram_code;
    logic [ATTR_W-1:0] ram_attr;

    cmc_host #(.ADDR_W(ADDR_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ram_code  (ram_code),
        .ram_attr  (ram_attr),
        .h_re      (h_re),
        .h_we_code (h_we_code),
        .h_we_attr (h_we_attr),
        .h_addr    (h_addr),
        .h_code    (h_code),
        .h_attr    (h_attr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    cmc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .h_re           (h_re),
        .h_we_code      (h_we_code),
        .h_we_attr      (h_we_attr),
        .h_addr         (h_addr),
        .disp_req       (disp_req),
        .disp_addr      (disp_addr),
        .ram_addr       (ram_addr),
        .ram_re         (ram_re),
        .ram_we_code    (ram_we_code),
        .ram_we_attr    (ram_we_attr),
        .disp_valid     (disp_valid),
        .disp_collision (disp_collision)
    );

    cmc_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .addr    (ram_addr),
        .re      (ram_re),
        .we_code (ram_we_code),
        .we_attr (ram_we_attr),
        .wcode   (h_code),
        .wattr   (h_attr),
        .rcode   (ram_code),
        .rattr   (ram_attr)
    );

    assign disp_code = ram_code;
    assign disp_attr = ram_attr;
endmodule

// File: tb/char_mem_ctrl_test.sv
module char_mem_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       disp_req = 1'b0;
    logic [8:0] disp_addr = '0;
    logic       disp_valid;
    logic [7:0] disp_code;
    logic [2:0] disp_attr;
    logic       disp_collision;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    char_mem_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .disp_req(disp_req), .disp_addr(disp_addr),
        .disp_valid(disp_valid), .disp_code(disp_code), .disp_attr(disp_attr),
        .disp_collision(disp_collision)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
        check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({req, " rd_data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic fetch(input logic [8:0] a, input logic [7:0] code, input logic [2:0] attr,
                         input string req);
        @(negedge clk);
        disp_req = 1'b1; disp_addr = a;
        @(negedge clk);
        disp_req = 1'b0;
        check({req, " disp_valid"}, 32'(disp_valid), 32'd1);
        check({req, " disp_collision"}, 32'(disp_collision), 32'd0);
        check({req, " disp_code"}, 32'(disp_code), 32'(code));
        check({req, " disp_attr"}, 32'(disp_attr), 32'(attr));
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        wr(3'd1, hi);
        wr(3'd2, lo);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 disp_valid", 32'(disp_valid), 32'd0);
        check("R1 disp_collision", 32'(disp_collision), 32'd0);
        rd(3'd0, 8'h00, "R1 mode");
        rd(3'd1, 8'h00, "R1 addr_hi");
        rd(3'd2, 8'h00, "R1 addr_lo");
    endtask

    task automatic t_regs;
        wr(3'd0, 8'h28);
        rd(3'd0, 8'h28, "R2 mode");
        wr(3'd1, 8'h03);
        rd(3'd1, 8'h03, "R2 addr_hi");
        wr(3'd2, 8'h5A);
        rd(3'd2, 8'h5A, "R2 addr_lo");
    endtask

    task automatic t_word;
        wr(3'd0, 8'h28);             // word mode, attribute 5
        set_addr(8'h01, 8'h05);      // location 0x105
        wr(3'd3, 8'h41);
        rd(3'd2, 8'h05, "R3 address held");
        rd(3'd4, 8'h41, "R5 code byte");
        rd(3'd5, 8'h05, "R5 attribute byte");
        fetch(9'h105, 8'h41, 3'd5, "R3 stored word");
    endtask

    task automatic t_byte;
        wr(3'd0, 8'h40);             // byte mode, mode attribute 0
        set_addr(8'h01, 8'h05);      // plane 0
        wr(3'd3, 8'h7E);
        fetch(9'h105, 8'h7E, 3'd5, "R4 code plane only");
        wr(3'd1, 8'h03);             // plane 1
        wr(3'd3, 8'h10);             // bits [5:3] = 2
        fetch(9'h105, 8'h7E, 3'd2, "R4 attribute plane only");
        rd(3'd4, 8'h02, "R6 attribute plane read");
        wr(3'd1, 8'h01);
        rd(3'd4, 8'h7E, "R6 code plane read");
    endtask

    task automatic t_stream;
        wr(3'd0, 8'h00);
        set_addr(8'h00, 8'h01);
        wr(3'd3, 8'h99);             // location 1 holds 0x99 / 0
        wr(3'd0, 8'h59);             // byte bit set, attribute 3, stream on
        set_addr(8'h01, 8'hFE);      // location 510
        wr(3'd3, 8'h11);
        wr(3'd3, 8'h22);
        wr(3'd3, 8'h33);
        rd(3'd1, 8'h00, "R7 wrapped addr_hi");
        rd(3'd2, 8'h01, "R7 wrapped addr_lo");
        wr(3'd3, 8'hFF);
        rd(3'd0, 8'h58, "R8 stream bit cleared");
        rd(3'd2, 8'h01, "R8 address unchanged");
        rd(3'd1, 8'h00, "R8 addr_hi unchanged");
        fetch(9'h1FE, 8'h11, 3'd3, "R7 location 510");
        fetch(9'h1FF, 8'h22, 3'd3, "R7 location 511");
        fetch(9'h000, 8'h33, 3'd3, "R7 location 0");
        fetch(9'h001, 8'h99, 3'd0, "R8 nothing stored");
    endtask

    task automatic t_collision;
        wr(3'd0, 8'h00);
        set_addr(8'h01, 8'h05);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 8'h55;
        disp_req = 1'b1; disp_addr = 9'h105;
        @(negedge clk);
        reg_wr = 1'b0; disp_req = 1'b0;
        check("R10 write drop valid", 32'(disp_valid), 32'd0);
        check("R10 write drop flag", 32'(disp_collision), 32'd1);
        fetch(9'h105, 8'h55, 3'd0, "R10 host write completed");
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = 3'd4;
        disp_req = 1'b1; disp_addr = 9'h000;
        @(negedge clk);
        reg_rd = 1'b0; disp_req = 1'b0;
        check("R10 read drop valid", 32'(disp_valid), 32'd0);
        check("R10 read drop flag", 32'(disp_collision), 32'd1);
        check("R10 host read data", 32'(rd_data), 32'h55);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 8'h01;
        disp_req = 1'b1; disp_addr = 9'h105;
        @(negedge clk);
        reg_wr = 1'b0; disp_req = 1'b0;
        check("R10 register write no drop", 32'(disp_valid), 32'd1);
        check("R10 register write no flag", 32'(disp_collision), 32'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 8'hFF;
        disp_req = 1'b1; disp_addr = 9'h105;
        @(negedge clk);
        reg_wr = 1'b0; disp_req = 1'b0;
        check("R10 terminator no drop", 32'(disp_valid), 32'd1);
        check("R10 terminator no flag", 32'(disp_collision), 32'd0);
        check("R10 terminator fetch code", 32'(disp_code), 32'h55);
        rd(3'd0, 8'h00, "R8 terminator during fetch");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_word();
        t_byte();
        t_stream();
        t_collision();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule